// File: doc/BRIEF.md
# Single-Beat Read Sequencer with Address-Phase Timeout Handling

This block issues one 32-bit read at a time onto a shared system bus for a bus master. User logic hands it a read request with an address and byte enables. The block places its request, the address and the transfer qualifiers on the bus, then waits for the address phase to end. Either the target acknowledges the address, or the bus reports a timeout.

When the address is acknowledged, the block waits for one read-data acknowledge. It captures the word and hands it to a streaming read port as a single frame: start and end of frame are marked on the same beat. It then reports completion with no error.

When the bus times out first, the block behaves differently. On the next clock it pulls its request and qualifiers off the bus. It reports a command timeout and an error with the completion pulse, and it raises a master error flag that stays set until the bus-side reset. It also signals a discontinue on the read stream instead of presenting any data. Only one command is in flight at a time.

Top module: `bus_rd_seq`

## Requirements
- R1: After reset, bus_req, bus_rnw, bus_addr and bus_be are 0; all stream strobes (st_src_rdy_n, st_sof_n, st_eof_n, st_src_dsc_n) are 1; mstr_err, usr_cmd_ack, usr_done, usr_err and usr_cmd_timeout are 0.
- R2: A usr_rd_req seen while idle places the command on the bus in the next cycle. In that cycle bus_req=1, bus_addr and bus_be equal the latched command, bus_rnw=1, bus_size=0 and bus_type=0. usr_cmd_ack is high for that first cycle only. The qualifiers stay stable until the address phase ends.
- R3: If bus_timeout is high while bus_req is high, then in the next cycle bus_req, bus_rnw, bus_addr and bus_be are all 0.
- R4: A timeout during the address phase sets mstr_err from the next cycle on. Only rst clears it.
- R5: In the cycle after an address-phase timeout, usr_done, usr_err and usr_cmd_timeout are each high for exactly one cycle.
- R6: After a timeout, st_src_dsc_n is low from the next cycle until the first cycle in which st_dst_rdy_n is low, and no later than that cycle. During this time st_src_rdy_n stays 1.
- R7: An address acknowledge with no timeout in the same cycle ends the address phase: bus_req is 0 from the next cycle. If the acknowledge and the timeout arrive in the same cycle, the block treats it as a timeout.
- R8: The word on bus_rd_data in the cycle bus_rd_ack is high, after the address was acknowledged, appears on st_data in the next cycle. It is presented with st_src_rdy_n, st_sof_n and st_eof_n all low, and held until st_dst_rdy_n is low.
- R9: In the cycle after the stream beat is accepted, usr_done is high for one cycle, with usr_err and usr_cmd_timeout low.
- R10: usr_rd_req while a command is still in progress, including during the discontinue wait, produces no usr_cmd_ack and no bus request.
- R11: bus_timeout outside the address phase has no effect on mstr_err, usr_done or the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high bus-side reset |
| usr_rd_req | input | 1 | User read command request |
| usr_addr | input | 32 | User command address |
| usr_be | input | 4 | User command byte enables |
| usr_cmd_ack | output | 1 | Command accepted pulse |
| usr_done | output | 1 | Command complete pulse |
| usr_err | output | 1 | Error flag accompanying usr_done |
| usr_cmd_timeout | output | 1 | Timeout status accompanying usr_done |
| bus_req | output | 1 | Bus request |
| bus_addr | output | 32 | Bus address |
| bus_be | output | 4 | Bus byte enables |
| bus_rnw | output | 1 | Read-not-write qualifier |
| bus_size | output | 4 | Transfer size qualifier (0 = single beat) |
| bus_type | output | 3 | Transfer type qualifier (0 = memory) |
| bus_addr_ack | input | 1 | Address acknowledge from bus |
| bus_timeout | input | 1 | Bus timeout indication |
| bus_rd_data | input | 32 | Read data from bus |
| bus_rd_ack | input | 1 | Read data acknowledge |
| mstr_err | output | 1 | Sticky master error |
| st_data | output | 32 | Stream read data |
| st_sof_n | output | 1 | Start of frame, active low |
| st_eof_n | output | 1 | End of frame, active low |
| st_src_rdy_n | output | 1 | Source ready, active low |
| st_src_dsc_n | output | 1 | Source discontinue, active low |
| st_dst_rdy_n | input | 1 | Destination ready, active low |

## Verification
The assertions check several rules on every cycle:
- the bus request drops one cycle after a timeout;
- the error flag is sticky;
- a discontinue never overlaps a data beat, and every data beat carries both frame markers;
- the qualifiers hold fixed values and stay stable while requesting;
- acknowledge and completion are single-cycle pulses.

Other behaviour depends on the sequence of stimulus, so only the bench scenarios can show it. This covers the exact cycle in which status and data appear, the word that reaches the stream, and the rejection of commands while busy. It also covers how a simultaneous acknowledge and timeout is resolved, and the fact that a late timeout is ignored. These scenarios are swept over every byte-enable value, several address-phase waits and several destination-ready delays.

// File: rtl/brm_pkg.sv
package brm_pkg;

    localparam int unsigned BRM_SIZE_W = 4;
    localparam int unsigned BRM_TYPE_W = 3;

    localparam logic [BRM_SIZE_W-1:0] SIZE_ONE_BEAT = '0;
    localparam logic [BRM_TYPE_W-1:0] TYPE_MEMORY   = '0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_SEND,
        ST_ABORT
    } brm_state_e;

    typedef struct packed {
        logic done;
        logic err;
        logic timeout;
    } brm_status_t;

    function automatic logic in_addr_phase(brm_state_e s);
        return s == ST_ADDR;
    endfunction

    function automatic logic can_accept(brm_state_e s);
        return s == ST_IDLE;
    endfunction

endpackage

// File: rtl/brm_fsm.sv
module brm_fsm
    import brm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        usr_rd_req,
    input  logic        bus_addr_ack,
    input  logic        bus_timeout,
    input  logic        bus_rd_ack,
    input  logic        st_dst_rdy_n,
    output brm_state_e  state,
    output logic        accept,
    output logic        timeout_hit,
    output logic        cmd_ack,
    output brm_status_t status
);

    brm_state_e  state_q, state_d;
    logic        ack_q;
    brm_status_t stat_q;
    logic        beat_taken;

    assign accept      = can_accept(state_q) && usr_rd_req;
    assign timeout_hit = in_addr_phase(state_q) && bus_timeout;
    assign beat_taken  = (state_q == ST_SEND) && !st_dst_rdy_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (usr_rd_req)    state_d = ST_ADDR;
            ST_ADDR: begin
                if (bus_timeout)         state_d = ST_ABORT;
                else if (bus_addr_ack)   state_d = ST_DATA;
            end
            ST_DATA:  if (bus_rd_ack)    state_d = ST_SEND;
            ST_SEND:  if (!st_dst_rdy_n) state_d = ST_IDLE;
            ST_ABORT: if (!st_dst_rdy_n) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
            stat_q  <= '0;
        end else begin
            state_q        <= state_d;
            ack_q          <= accept;
            stat_q.done    <= timeout_hit || beat_taken;
            stat_q.err     <= timeout_hit;
            stat_q.timeout <= timeout_hit;
        end
    end

    assign state   = state_q;
    assign cmd_ack = ack_q;
    assign status  = stat_q;

    // R2: the command acknowledge lasts a single cycle
    a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> !cmd_ack);

    // R5: the completion pulse lasts a single cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        status.done |=> !status.done);

    // R5: error and timeout status only appear with completion
    a_r5_err_with_done: assert property (@(posedge clk) disable iff (rst)
        status.err |-> (status.done && status.timeout));

    // R10: no acknowledge while a command is still in progress
    a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ABORT) |=> !cmd_ack);

endmodule

// File: rtl/brm_bus_drv.sv
module brm_bus_drv
    import brm_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  brm_state_e            state,
    input  logic                  accept,
    input  logic [ADDR_W-1:0]     usr_addr,
    input  logic [BE_W-1:0]       usr_be,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [BE_W-1:0]       bus_be,
    output logic                  bus_rnw,
    output logic [BRM_SIZE_W-1:0] bus_size,
    output logic [BRM_TYPE_W-1:0] bus_type
);

    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic              drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            be_q   <= '0;
        end else if (accept) begin
            addr_q <= usr_addr;
            be_q   <= usr_be;
        end
    end

    assign drive    = in_addr_phase(state);
    assign bus_req  = drive;
    assign bus_rnw  = drive;
    assign bus_addr = drive ? addr_q : '0;
    assign bus_be   = drive ? be_q   : '0;
    assign bus_size = SIZE_ONE_BEAT;
    assign bus_type = TYPE_MEMORY;

    // R2: a single-beat read always carries fixed qualifiers
    a_r2_qualifiers: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_rnw && bus_size == '0 && bus_type == '0));

    // R2: address and byte enables hold while the request stays up
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_be)));

endmodule

// File: rtl/brm_stream.sv
module brm_stream
    import brm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  brm_state_e        state,
    input  logic              bus_rd_ack,
    input  logic [DATA_W-1:0] bus_rd_data,
    output logic [DATA_W-1:0] st_data,
    output logic              st_sof_n,
    output logic              st_eof_n,
    output logic              st_src_rdy_n,
    output logic              st_src_dsc_n
);

    logic [DATA_W-1:0] word_q;
    logic              sending;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (state == ST_DATA && bus_rd_ack) begin
            word_q <= bus_rd_data;
        end
    end

    assign sending      = (state == ST_SEND);
    assign st_data      = word_q;
    assign st_src_rdy_n = !sending;
    assign st_sof_n     = !sending;
    assign st_eof_n     = !sending;
    assign st_src_dsc_n = (state != ST_ABORT);

    // R6: a discontinue never coincides with a data beat
    a_r6_dsc_no_beat: assert property (@(posedge clk) disable iff (rst)
        !st_src_dsc_n |-> st_src_rdy_n);

    // R8: every beat is a whole one-word frame
    a_r8_single_frame: assert property (@(posedge clk) disable iff (rst)
        !st_src_rdy_n |-> (!st_sof_n && !st_eof_n));

endmodule

// File: rtl/brm_err_flag.sv
module brm_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic timeout_hit,
    output logic mstr_err
);

    logic err_q;

    always_ff @(posedge clk) begin
        if (rst)              err_q <= 1'b0;
        else if (timeout_hit) err_q <= 1'b1;
    end

    assign mstr_err = err_q;

    // R4: once set, the error is held until reset
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        mstr_err |=> mstr_err);

endmodule

// File: rtl/bus_rd_seq.sv
module bus_rd_seq
    import brm_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  usr_rd_req,
    input  logic [ADDR_W-1:0]     usr_addr,
    input  logic [BE_W-1:0]       usr_be,
    output logic                  usr_cmd_ack,
    output logic                  usr_done,
    output logic                  usr_err,
    output logic                  usr_cmd_timeout,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [BE_W-1:0]       bus_be,
    output logic                  bus_rnw,
    output logic [BRM_SIZE_W-1:0] bus_size,
    output logic [BRM_TYPE_W-1:0] bus_type,
    input  logic                  bus_addr_ack,
    input  logic                  bus_timeout,
    input  logic [DATA_W-1:0]     bus_rd_data,
    input  logic                  bus_rd_ack,
    output logic                  mstr_err,
    output logic [DATA_W-1:0]     st_data,
    output logic                  st_sof_n,
    output logic                  st_eof_n,
    output logic                  st_src_rdy_n,
    output logic                  st_src_dsc_n,
    input  logic                  st_dst_rdy_n
);

    brm_state_e  state;
    logic        accept;
    logic        timeout_hit;
    brm_status_t status;

    brm_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .usr_rd_req   (usr_rd_req),
        .bus_addr_ack (bus_addr_ack),
        .bus_timeout  (bus_timeout),
        .bus_rd_ack   (bus_rd_ack),
        .st_dst_rdy_n (st_dst_rdy_n),
        .state        (state),
        .accept       (accept),
        .timeout_hit  (timeout_hit),
        .cmd_ack      (usr_cmd_ack),
        .status       (status)
    );

    brm_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .accept   (accept),
        .usr_addr (usr_addr),
        .usr_be   (usr_be),
        .bus_req  (bus_req),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_rnw  (bus_rnw),
        .bus_size (bus_size),
        .bus_type (bus_type)
    );

    brm_stream #(.DATA_W(DATA_W)) u_stream (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .bus_rd_ack   (bus_rd_ack),
        .bus_rd_data  (bus_rd_data),
        .st_data      (st_data),
        .st_sof_n     (st_sof_n),
        .st_eof_n     (st_eof_n),
        .st_src_rdy_n (st_src_rdy_n),
        .st_src_dsc_n (st_src_dsc_n)
    );

    brm_err_flag u_err (
        .clk         (clk),
        .rst         (rst),
        .timeout_hit (timeout_hit),
        .mstr_err    (mstr_err)
    );

    assign usr_done        = status.done;
    assign usr_err         = status.err;
    assign usr_cmd_timeout = status.timeout;

    // R3: a timeout removes the request on the following cycle
    a_r3_req_drop: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_timeout) |=> (!bus_req && bus_addr == '0));

    // R4: a timeout during a request raises the master error next cycle
    a_r4_err_set: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_timeout) |=> mstr_err);

    // R7: an address acknowledge alone ends the request
    a_r7_ack_drop: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr_ack && !bus_timeout) |=> (!bus_req && !usr_err));

    // R5: a timeout reports status to the user on the following cycle
    a_r5_status: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_timeout) |=> (usr_done && usr_err && usr_cmd_timeout));

endmodule

// File: tb/bus_rd_seq_tb.sv
module bus_rd_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        usr_rd_req;
    logic [31:0] usr_addr;
    logic [3:0]  usr_be;
    logic        usr_cmd_ack, usr_done, usr_err, usr_cmd_timeout;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_rnw;
    logic [3:0]  bus_size;
    logic [2:0]  bus_type;
    logic        bus_addr_ack, bus_timeout, bus_rd_ack;
    logic [31:0] bus_rd_data;
    logic        mstr_err;
    logic [31:0] st_data;
    logic        st_sof_n, st_eof_n, st_src_rdy_n, st_src_dsc_n, st_dst_rdy_n;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bus_rd_seq u_dut (
        .clk(clk), .rst(rst),
        .usr_rd_req(usr_rd_req), .usr_addr(usr_addr), .usr_be(usr_be),
        .usr_cmd_ack(usr_cmd_ack), .usr_done(usr_done), .usr_err(usr_err),
        .usr_cmd_timeout(usr_cmd_timeout),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_be(bus_be), .bus_rnw(bus_rnw),
        .bus_size(bus_size), .bus_type(bus_type),
        .bus_addr_ack(bus_addr_ack), .bus_timeout(bus_timeout),
        .bus_rd_data(bus_rd_data), .bus_rd_ack(bus_rd_ack),
        .mstr_err(mstr_err),
        .st_data(st_data), .st_sof_n(st_sof_n), .st_eof_n(st_eof_n),
        .st_src_rdy_n(st_src_rdy_n), .st_src_dsc_n(st_src_dsc_n),
        .st_dst_rdy_n(st_dst_rdy_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [31:0] addr, input logic [3:0] be,
                           input int wt, input int mode, input int rd);
        logic [31:0] dat;
        dat = (addr * 32'd2654435761) ^ {28'h5A3C96E, be};
        usr_rd_req = 1'b1; usr_addr = addr; usr_be = be;
        step();
        usr_rd_req = 1'b0; usr_addr = '1; usr_be = '1;
        chk("R2 req",   bus_req,     1);
        chk("R2 addr",  bus_addr,    addr);
        chk("R2 be",    bus_be,      be);
        chk("R2 rnw",   bus_rnw,     1);
        chk("R2 size",  bus_size,    0);
        chk("R2 type",  bus_type,    0);
        chk("R2 ack",   usr_cmd_ack, 1);
        for (int i = 0; i < wt; i++) begin
            step();
            chk("R2 hold req",  bus_req,     1);
            chk("R2 hold addr", bus_addr,    addr);
            chk("R2 ack once",  usr_cmd_ack, 0);
        end
        bus_addr_ack = (mode != 1);
        bus_timeout  = (mode != 0);
        step();
        bus_addr_ack = 1'b0; bus_timeout = 1'b0;
        if (mode != 0) begin
            chk("R3 req",     bus_req,         0);
            chk("R3 addr",    bus_addr,        0);
            chk("R3 be",      bus_be,          0);
            chk("R3 rnw",     bus_rnw,         0);
            chk("R4 err set", mstr_err,        1);
            chk("R5 done",    usr_done,        1);
            chk("R5 err",     usr_err,         1);
            chk("R5 timeout", usr_cmd_timeout, 1);
            chk("R6 dsc",     st_src_dsc_n,    0);
            chk("R6 no beat", st_src_rdy_n,    1);
            if (mode == 2) chk("R7 tie is timeout", usr_cmd_timeout, 1);
            if (rd > 0) begin
                usr_rd_req = 1'b1; usr_addr = addr ^ 32'h40;
            end
            for (int i = 0; i < rd; i++) begin
                step();
                usr_rd_req = 1'b0;
                chk("R10 no ack",  usr_cmd_ack,  0);
                chk("R10 no req",  bus_req,      0);
                chk("R6 dsc held", st_src_dsc_n, 0);
                chk("R6 no beat",  st_src_rdy_n, 1);
                chk("R5 one pulse", usr_done,    0);
            end
            st_dst_rdy_n = 1'b0;
            step();
            st_dst_rdy_n = 1'b1;
            chk("R6 dsc end",  st_src_dsc_n, 1);
            chk("R4 err held", mstr_err,     1);
            chk("R10 idle",    bus_req,      0);
            rst = 1'b1;
            step();
            rst = 1'b0;
            chk("R4 rst clears", mstr_err, 0);
            chk("R1 stream idle", st_src_dsc_n, 1);
        end else begin
            chk("R7 req drop", bus_req,     0);
            chk("R7 no done",  usr_done,    0);
            chk("R7 no ack",   usr_cmd_ack, 0);
            bus_timeout = 1'b1;
            step();
            bus_timeout = 1'b0;
            chk("R11 err",  mstr_err,     0);
            chk("R11 done", usr_done,     0);
            chk("R11 dsc",  st_src_dsc_n, 1);
            bus_rd_data = dat; bus_rd_ack = 1'b1;
            step();
            bus_rd_ack = 1'b0; bus_rd_data = '0;
            chk("R8 data", st_data,      dat);
            chk("R8 rdy",  st_src_rdy_n, 0);
            chk("R8 sof",  st_sof_n,     0);
            chk("R8 eof",  st_eof_n,     0);
            chk("R8 dsc",  st_src_dsc_n, 1);
            for (int i = 0; i < rd; i++) begin
                step();
                chk("R8 held data", st_data,      dat);
                chk("R8 held rdy",  st_src_rdy_n, 0);
                chk("R9 early",     usr_done,     0);
            end
            st_dst_rdy_n = 1'b0;
            step();
            st_dst_rdy_n = 1'b1;
            chk("R9 done",    usr_done,        1);
            chk("R9 err",     usr_err,         0);
            chk("R9 timeout", usr_cmd_timeout, 0);
            chk("R9 rdy off", st_src_rdy_n,    1);
            chk("R9 mstr",    mstr_err,        0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; usr_rd_req = 1'b0; usr_addr = '0; usr_be = '0;
        bus_addr_ack = 1'b0; bus_timeout = 1'b0; bus_rd_ack = 1'b0;
        bus_rd_data = '0; st_dst_rdy_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 req",  bus_req,         0);
        chk("R1 rnw",  bus_rnw,         0);
        chk("R1 addr", bus_addr,        0);
        chk("R1 be",   bus_be,          0);
        chk("R1 rdy",  st_src_rdy_n,    1);
        chk("R1 sof",  st_sof_n,        1);
        chk("R1 eof",  st_eof_n,        1);
        chk("R1 dsc",  st_src_dsc_n,    1);
        chk("R1 err",  mstr_err,        0);
        chk("R1 ack",  usr_cmd_ack,     0);
        chk("R1 done", usr_done,        0);
        chk("R1 uerr", usr_err,         0);
        chk("R1 to",   usr_cmd_timeout, 0);
        for (int be = 0; be < 16; be++)
            for (int wt = 0; wt < 4; wt++)
                for (int mode = 0; mode < 3; mode++)
                    for (int rd = 0; rd < 3; rd++)
                        run_cmd(32'h1000_0000 + 32'(be * 4) + 32'(wt * 256) + 32'(rd * 4096),
                                4'(be), wt, mode, rd);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule